// File: doc/BRIEF.md
# Predicated Vector Element Sequencer

This block walks a vector operation element by element. After an accepted start pulse it steps an element index from zero up to the vector length minus one, one index per clock. For each index it reports whether that element executes, is skipped, or has its destination forced to zero. The element datapath and writeback sit downstream and consume this command stream. When the walk ends, the block gives a one-cycle done pulse.

The per-element enable comes from one of two predicate sources, chosen by a mode bit. In integer mode, a 3-bit selector picks one of three scalar register values: r3, r10 or r30. The selector tests bit i of that value as set or clear, or it enables only the element whose index equals r3. In condition mode, the selector picks one of the four flags of a 4-bit condition field, tested as set or clear. Element i reads the field at a fixed base offset plus i. Elements whose predicate is false are either skipped or zeroed, as set by a zero-fill bit.

All operands are captured on the accepted start. After that they may change freely without affecting the running sequence.

Top module: `vec_pred_sequencer`

## Requirements
- R1: A start accepted with `vl` equal to 0 issues no element (`elem_valid` stays low), and `done` is high for one cycle, in the cycle after the start edge.
- R2: A start accepted while idle with `vl` = N issues elements in N consecutive cycles, beginning in the cycle after the start edge, with `elem_idx` = 0, 1, …, N−1. Values of `vl` above 64 are treated as 64.
- R3: With `mask_kind` = 0 and `mask_sel` = 000, every issued element has action 01 (execute).
- R4: With `mask_kind` = 0 and `mask_sel` = 001, only the element whose index equals the full 64-bit value of r3 is enabled. If r3 is 64 or more, no element is enabled.
- R5: With `mask_kind` = 0, selectors 010/011 enable element i when bit i of r3 is set/clear. Selectors 100/101 do the same for r10, and 110/111 for r30. Bit i is counted from the LSB.
- R6: With `mask_kind` = 1, element i reads condition field 32+i, which is `cr_fields[4k+3:4k]` for k = 32+i. Within a field, bit 3 is LT, bit 2 is GT, bit 1 is EQ and bit 0 is SO. Selectors 000/010/100/110 enable when LT/GT/EQ/SO is set. Selectors 001/011/101/111 enable when the same flag is clear.
- R7: In condition mode, an element whose field number 32+i exceeds 63 is disabled.
- R8: An issued element has action 01 when enabled. When disabled, it has action 10 if `zero_fill` is 1 and action 00 if `zero_fill` is 0. `elem_act` is 00 whenever `elem_valid` is low.
- R9: A start that arrives while a sequence is running is ignored. All operands (`vl`, mode, selector, `zero_fill`, r3, r10, r30, condition fields) are taken only at the accepted start.
- R10: `done` rises in the cycle after the last element is issued, lasts exactly one cycle, and `elem_valid` is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse |
| vl | input | 7 | Vector length (0..64, larger values clamp to 64) |
| mask_kind | input | 1 | Predicate source: 0 integer register, 1 condition field |
| mask_sel | input | 3 | Predicate selector |
| zero_fill | input | 1 | 1: disabled elements write zero; 0: they are skipped |
| gpr_r3 | input | 64 | Scalar value of r3 |
| gpr_r10 | input | 64 | Scalar value of r10 |
| gpr_r30 | input | 64 | Scalar value of r30 |
| cr_fields | input | 256 | 64 condition fields of 4 bits; field k at [4k+3:4k] |
| elem_valid | output | 1 | An element command is present this cycle |
| elem_idx | output | 6 | Element index |
| elem_act | output | 2 | 01 execute, 10 write zero, 00 skip |
| done | output | 1 | One-cycle end-of-sequence pulse |

## Verification
The bench builds the block with its default parameters: a maximum length of 64, 64-bit registers, 64 condition fields and a condition base of 32. With that base, any sequence longer than 32 elements runs past the last field, so the out-of-range rule of R7 is exercised on every long condition-mode run. With a 7-bit length port, lengths above 64 are also reachable, which exercises the clamp in R2. During each run the operand inputs are inverted right after the start edge. Any leak of live inputs into a running sequence therefore shows up as wrong actions.

// File: rtl/vps_pkg.sv
package vps_pkg;

  parameter int unsigned VPS_XLEN      = 64;
  parameter int unsigned VPS_MAX_VL    = 64;
  parameter int unsigned VPS_CR_FIELDS = 64;
  parameter int unsigned VPS_CR_BASE   = 32;

  typedef enum logic [1:0] {
    ACT_SKIP = 2'b00,
    ACT_EXEC = 2'b01,
    ACT_ZERO = 2'b10
  } act_e;

  // Integer predicate from pre-selected bits: one-hot hit and bit i of each register.
  function automatic logic int_pred(input logic [2:0] sel, input logic onehot_hit,
                                    input logic b3, input logic b10, input logic b30);
    logic res;
    case (sel)
      3'd0:    res = 1'b1;
      3'd1:    res = onehot_hit;
      3'd2:    res = b3;
      3'd3:    res = ~b3;
      3'd4:    res = b10;
      3'd5:    res = ~b10;
      3'd6:    res = b30;
      default: res = ~b30;
    endcase
    return res;
  endfunction

  // Condition predicate: sel[2:1] picks LT(3) GT(2) EQ(1) SO(0), sel[0] inverts.
  function automatic logic cr_pred(input logic [2:0] sel, input logic [3:0] field);
    logic flag;
    case (sel[2:1])
      2'd0:    flag = field[3];
      2'd1:    flag = field[2];
      2'd2:    flag = field[1];
      default: flag = field[0];
    endcase
    return flag ^ sel[0];
  endfunction

  function automatic act_e pick_act(input logic valid, input logic pass, input logic zfill);
    act_e a;
    if (!valid)     a = ACT_SKIP;
    else if (pass)  a = ACT_EXEC;
    else if (zfill) a = ACT_ZERO;
    else            a = ACT_SKIP;
    return a;
  endfunction

endpackage

// File: rtl/vps_ctrl.sv
module vps_ctrl #(
  parameter int unsigned MAX_VL = 64,
  localparam int unsigned IDX_W = $clog2(MAX_VL),
  localparam int unsigned VL_W  = $clog2(MAX_VL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [VL_W-1:0]  vl_i,
  output logic             accept_o,
  output logic             busy_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             last_o,
  output logic             done_o
);
  logic [VL_W-1:0]  vl_q;
  logic [IDX_W-1:0] idx_q;
  logic             busy_q;
  logic             done_q;
  logic [VL_W-1:0]  vl_eff;

  assign vl_eff   = (vl_i > VL_W'(MAX_VL)) ? VL_W'(MAX_VL) : vl_i;
  assign accept_o = start_i && !busy_q;
  assign last_o   = busy_q && (VL_W'(idx_q) == (vl_q - 1'b1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vl_q   <= '0;
      idx_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept_o) begin
        vl_q  <= vl_eff;
        idx_q <= '0;
        if (vl_eff == '0) done_q <= 1'b1;
        else              busy_q <= 1'b1;
      end else if (busy_q) begin
        if (last_o) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign idx_o  = idx_q;
  assign done_o = done_q;
endmodule

// File: rtl/vps_pred.sv
module vps_pred
  import vps_pkg::*;
#(
  parameter int unsigned XLEN      = 64,
  parameter int unsigned MAX_VL    = 64,
  parameter int unsigned CR_FIELDS = 64,
  parameter int unsigned CR_BASE   = 32,
  localparam int unsigned IDX_W = $clog2(MAX_VL),
  localparam int unsigned CRS_W = $clog2(CR_FIELDS),
  localparam int unsigned CRN_W = $clog2(CR_BASE + MAX_VL + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   capture_i,
  input  logic                   kind_i,
  input  logic [2:0]             sel_i,
  input  logic                   zfill_i,
  input  logic [XLEN-1:0]        r3_i,
  input  logic [XLEN-1:0]        r10_i,
  input  logic [XLEN-1:0]        r30_i,
  input  logic [4*CR_FIELDS-1:0] cr_i,
  input  logic [IDX_W-1:0]       idx_i,
  output logic                   pass_o,
  output logic                   zfill_o,
  output logic                   kind_o,
  output logic [2:0]             sel_o,
  output logic                   cr_in_range_o
);
  logic                   kind_q, zfill_q;
  logic [2:0]             sel_q;
  logic [XLEN-1:0]        r3_q, r10_q, r30_q;
  logic [4*CR_FIELDS-1:0] cr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q  <= 1'b0;
      zfill_q <= 1'b0;
      sel_q   <= '0;
      r3_q    <= '0;
      r10_q   <= '0;
      r30_q   <= '0;
      cr_q    <= '0;
    end else if (capture_i) begin
      kind_q  <= kind_i;
      zfill_q <= zfill_i;
      sel_q   <= sel_i;
      r3_q    <= r3_i;
      r10_q   <= r10_i;
      r30_q   <= r30_i;
      cr_q    <= cr_i;
    end
  end

  // integer side
  logic onehot_hit, int_ok;
  assign onehot_hit = (r3_q == XLEN'(idx_i));
  assign int_ok = int_pred(sel_q, onehot_hit, r3_q[idx_i], r10_q[idx_i], r30_q[idx_i]);

  // condition side
  logic [CRN_W-1:0] cr_num;
  logic [CRS_W-1:0] cr_pick;
  logic [3:0]       cr_field;
  logic             cr_ok;
  assign cr_num        = CRN_W'(CR_BASE) + CRN_W'(idx_i);
  assign cr_in_range_o = (cr_num < CRN_W'(CR_FIELDS));
  assign cr_pick       = cr_in_range_o ? cr_num[CRS_W-1:0] : '0;
  assign cr_field      = cr_q[{cr_pick, 2'b00} +: 4];
  assign cr_ok         = cr_in_range_o && cr_pred(sel_q, cr_field);

  assign pass_o  = kind_q ? cr_ok : int_ok;
  assign zfill_o = zfill_q;
  assign kind_o  = kind_q;
  assign sel_o   = sel_q;
endmodule

// File: rtl/vps_action.sv
module vps_action
  import vps_pkg::*;
(
  input  logic       valid_i,
  input  logic       pass_i,
  input  logic       zfill_i,
  output logic [1:0] act_o
);
  act_e act;
  always_comb act = pick_act(valid_i, pass_i, zfill_i);
  assign act_o = act;
endmodule

// File: rtl/vec_pred_sequencer.sv
module vec_pred_sequencer
  import vps_pkg::*;
#(
  parameter int unsigned XLEN      = VPS_XLEN,
  parameter int unsigned MAX_VL    = VPS_MAX_VL,
  parameter int unsigned CR_FIELDS = VPS_CR_FIELDS,
  parameter int unsigned CR_BASE   = VPS_CR_BASE,
  localparam int unsigned IDX_W = $clog2(MAX_VL),
  localparam int unsigned VL_W  = $clog2(MAX_VL + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [VL_W-1:0]        vl,
  input  logic                   mask_kind,
  input  logic [2:0]             mask_sel,
  input  logic                   zero_fill,
  input  logic [XLEN-1:0]        gpr_r3,
  input  logic [XLEN-1:0]        gpr_r10,
  input  logic [XLEN-1:0]        gpr_r30,
  input  logic [4*CR_FIELDS-1:0] cr_fields,
  output logic                   elem_valid,
  output logic [IDX_W-1:0]       elem_idx,
  output logic [1:0]             elem_act,
  output logic                   done
);
  // named internal events
  logic             seq_accept;
  logic             seq_busy;
  logic             seq_last;
  logic [IDX_W-1:0] seq_idx;
  logic             elem_pass;
  logic             cfg_zfill;
  logic             cfg_kind;
  logic [2:0]       cfg_sel;
  logic             cr_in_range;

  vps_ctrl #(.MAX_VL(MAX_VL)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start), .vl_i(vl),
    .accept_o(seq_accept), .busy_o(seq_busy), .idx_o(seq_idx),
    .last_o(seq_last), .done_o(done)
  );

  vps_pred #(.XLEN(XLEN), .MAX_VL(MAX_VL), .CR_FIELDS(CR_FIELDS), .CR_BASE(CR_BASE)) u_pred (
    .clk(clk), .rst_n(rst_n), .capture_i(seq_accept),
    .kind_i(mask_kind), .sel_i(mask_sel), .zfill_i(zero_fill),
    .r3_i(gpr_r3), .r10_i(gpr_r10), .r30_i(gpr_r30), .cr_i(cr_fields),
    .idx_i(seq_idx), .pass_o(elem_pass), .zfill_o(cfg_zfill),
    .kind_o(cfg_kind), .sel_o(cfg_sel), .cr_in_range_o(cr_in_range)
  );

  vps_action u_act (
    .valid_i(seq_busy), .pass_i(elem_pass), .zfill_i(cfg_zfill), .act_o(elem_act)
  );

  assign elem_valid = seq_busy;
  assign elem_idx   = seq_idx;
endmodule

// File: rtl/vps_checker.sv
module vps_checker #(
  parameter int unsigned IDX_W = 6,
  parameter int unsigned VL_W  = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [VL_W-1:0]  vl,
  input logic             accept,
  input logic             busy,
  input logic             last,
  input logic [IDX_W-1:0] idx,
  input logic             done,
  input logic             elem_valid,
  input logic [1:0]       elem_act,
  input logic             kind_q,
  input logic [2:0]       sel_q,
  input logic             cr_in_range
);
  a_r1_vl_zero_nop: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (vl == '0) |=> done && !elem_valid);

  a_r2_first_index: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (vl != '0) |=> elem_valid && (idx == '0));

  a_r2_index_step: assert property (@(posedge clk) disable iff (!rst_n)
    elem_valid && !last |=> elem_valid && (idx == $past(idx) + 1'b1));

  a_r10_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    elem_valid && last |=> done && !elem_valid);

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    start && busy |-> !accept);

  a_r3_identity: assert property (@(posedge clk) disable iff (!rst_n)
    elem_valid && !kind_q && (sel_q == 3'b000) |-> elem_act == 2'b01);

  a_r7_cr_range: assert property (@(posedge clk) disable iff (!rst_n)
    elem_valid && kind_q && !cr_in_range |-> elem_act != 2'b01);

  a_r8_act_legal: assert property (@(posedge clk) disable iff (!rst_n)
    elem_valid |-> elem_act != 2'b11);
endmodule

bind vec_pred_sequencer vps_checker #(.IDX_W(IDX_W), .VL_W(VL_W)) u_vps_checker (
  .clk(clk), .rst_n(rst_n), .start(start), .vl(vl), .accept(seq_accept),
  .busy(seq_busy), .last(seq_last), .idx(seq_idx), .done(done),
  .elem_valid(elem_valid), .elem_act(elem_act), .kind_q(cfg_kind),
  .sel_q(cfg_sel), .cr_in_range(cr_in_range)
);

// File: tb/test_vec_pred_sequencer.sv
`timescale 1ns/1ps
module test_vec_pred_sequencer;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [6:0]   vl = '0;
  logic         mask_kind = 1'b0;
  logic [2:0]   mask_sel = '0;
  logic         zero_fill = 1'b0;
  logic [63:0]  gpr_r3 = '0, gpr_r10 = '0, gpr_r30 = '0;
  logic [255:0] cr_fields = '0;
  logic         elem_valid;
  logic [5:0]   elem_idx;
  logic [1:0]   elem_act;
  logic         done;
  logic [255:0] crs;
  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  vec_pred_sequencer i_vec_pred_sequencer (
    .clk(clk), .rst_n(rst_n), .start(start), .vl(vl), .mask_kind(mask_kind),
    .mask_sel(mask_sel), .zero_fill(zero_fill), .gpr_r3(gpr_r3), .gpr_r10(gpr_r10),
    .gpr_r30(gpr_r30), .cr_fields(cr_fields), .elem_valid(elem_valid),
    .elem_idx(elem_idx), .elem_act(elem_act), .done(done)
  );

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // Enable vector built directly from the requirement text.
  function automatic logic [63:0] want_mask(input logic k, input logic [2:0] s,
      input logic [63:0] a, input logic [63:0] b, input logic [63:0] c, input logic [255:0] cr);
    logic [63:0] m;
    m = '0;
    if (!k) begin
      case (s)
        3'd0: m = '1;
        3'd1: m = (a < 64) ? (64'd1 << a[5:0]) : 64'd0;
        3'd2: m = a;
        3'd3: m = ~a;
        3'd4: m = b;
        3'd5: m = ~b;
        3'd6: m = c;
        3'd7: m = ~c;
      endcase
    end else begin
      for (int e = 0; e < 64; e++) begin
        int n;
        int pos;
        logic [3:0] f;
        n = 32 + e;
        if (n < 64) begin
          f = cr[n*4 +: 4];
          pos = 3 - int'(s[2:1]);  // LT=3, GT=2, EQ=1, SO=0
          m[e] = s[0] ? ~f[pos] : f[pos];
        end
      end
    end
    return m;
  endfunction

  task automatic run_seq(input string tag, input logic [6:0] n, input logic k, input logic [2:0] s,
                         input logic z, input logic [63:0] a, input logic [63:0] b, input logic [63:0] c);
    logic [63:0] m;
    int eff;
    m = want_mask(k, s, a, b, c, crs);
    eff = (n > 64) ? 64 : int'(n);
    start = 1'b1; vl = n; mask_kind = k; mask_sel = s; zero_fill = z;
    gpr_r3 = a; gpr_r10 = b; gpr_r30 = c; cr_fields = crs;
    @(negedge clk);
    start = 1'b0;
    // scramble operands after the accepted start (R9)
    vl = ~n; mask_kind = ~k; mask_sel = ~s; zero_fill = ~z;
    gpr_r3 = ~a; gpr_r10 = ~b; gpr_r30 = ~c; cr_fields = ~crs;
    if (eff == 0) begin
      chk({tag, " R1 vl0"}, {62'd0, elem_valid, done}, 64'b01);
    end else begin
      for (int i = 0; i < eff; i++) begin
        logic [1:0] ea;
        ea = m[i] ? 2'b01 : (z ? 2'b10 : 2'b00);
        chk($sformatf("%s R2/R8 elem %0d", tag, i), {55'd0, elem_valid, elem_idx, elem_act},
            {55'd0, 1'b1, 6'(i), ea});
        @(negedge clk);
      end
      chk({tag, " R10 done"}, {62'd0, elem_valid, done}, 64'b01);
    end
    @(negedge clk);
    chk({tag, " R10 done single"}, {62'd0, elem_valid, done}, 64'b00);
  endtask

  task automatic t_reset();
    chk("reset R10", {61'd0, elem_valid, done, 1'b0}, 64'd0);
    chk("reset R8 act", {62'd0, elem_act}, 64'd0);
  endtask

  task automatic t_vl_zero();
    run_seq("R1 int", 7'd0, 1'b0, 3'd0, 1'b1, 64'd0, 64'd0, 64'd0);
    run_seq("R1 cr", 7'd0, 1'b1, 3'd3, 1'b1, 64'd0, 64'd0, 64'd0);
  endtask

  task automatic t_identity();
    run_seq("R3 full", 7'd64, 1'b0, 3'd0, 1'b0, 64'h0, 64'h0, 64'h0);
    run_seq("R3 zf", 7'd5, 1'b0, 3'd0, 1'b1, 64'h0, 64'h0, 64'h0);
  endtask

  task automatic t_onehot();
    run_seq("R4 hit", 7'd8, 1'b0, 3'd1, 1'b1, 64'd5, 64'd0, 64'd0);
    run_seq("R4 top", 7'd64, 1'b0, 3'd1, 1'b0, 64'd63, 64'd0, 64'd0);
    run_seq("R4 wide", 7'd64, 1'b0, 3'd1, 1'b1, 64'h1_0000_0005, 64'd0, 64'd0);
  endtask

  task automatic t_intmask();
    logic [63:0] a, b, c;
    a = 64'hF0E1_D2C3_B4A5_9687; b = 64'h8000_0000_0000_0001; c = 64'h5A5A_0FF0_3C3C_A5A5;
    for (int s = 2; s < 8; s++)
      run_seq($sformatf("R5 sel%0d", s), 7'd40 + 7'(s), 1'b0, 3'(s), s[0], a, b, c);
    run_seq("R5 msb", 7'd64, 1'b0, 3'd4, 1'b1, a, b, c);
  endtask

  task automatic t_crmask();
    for (int s = 0; s < 8; s++)
      run_seq($sformatf("R6 sel%0d", s), 7'd32, 1'b1, 3'(s), s[1], 64'd0, 64'd0, 64'd0);
    run_seq("R7 zf", 7'd40, 1'b1, 3'd1, 1'b1, 64'd0, 64'd0, 64'd0);
    run_seq("R7 skip", 7'd64, 1'b1, 3'd6, 1'b0, 64'd0, 64'd0, 64'd0);
  endtask

  task automatic t_clamp();
    run_seq("R2 clamp", 7'd100, 1'b0, 3'd2, 1'b1, 64'hAAAA_5555_0000_FFFF, 64'd0, 64'd0);
    run_seq("R2 one", 7'd1, 1'b0, 3'd3, 1'b1, 64'd1, 64'd0, 64'd0);
  endtask

  task automatic t_restart();
    start = 1'b1; vl = 7'd6; mask_kind = 1'b0; mask_sel = 3'd0; zero_fill = 1'b0;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 6; i++) begin
      chk($sformatf("R9 elem %0d", i), {55'd0, elem_valid, elem_idx, elem_act},
          {55'd0, 1'b1, 6'(i), 2'b01});
      if (i == 2) begin
        start = 1'b1; vl = 7'd3; mask_kind = 1'b1; mask_sel = 3'd7; zero_fill = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    chk("R9 done", {62'd0, elem_valid, done}, 64'b01);
    @(negedge clk);
    chk("R9 no restart", {62'd0, elem_valid, done}, 64'b00);
  endtask

  initial begin
    for (int k = 0; k < 64; k++) crs[k*4 +: 4] = 4'((k * 7 + 3) % 16);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_vl_zero();
    t_identity();
    t_onehot();
    t_intmask();
    t_crmask();
    t_clamp();
    t_restart();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog R2: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule